// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing slave of a byte-wide serial memory. It samples the two-wire clock and data lines with the system clock and recognises start and stop conditions. It decodes a one-byte device address, loads a two-byte word address, and then handles single-byte writes, current-address reads, random reads and sequential reads. It pulls the data line low through an output-enable signal and otherwise leaves it released. Reads are served from a synchronous memory port that returns data one cycle after the request. Writes are handed to the storage side as one commit pulse that carries the address and the data.

Each commit is followed by a busy window of `BUSY_CYCLES` system clocks, which stands in for the nonvolatile write time. During this window the block ignores the bus completely. A master can therefore poll with address bytes until it gets an acknowledge. An internal address counter tracks the next location. Sequential reads advance it across the whole array, wrapping to zero at the end. A write advances it only within the current page. When a write header ends with a stop, it sets the counter and writes nothing.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the block drives nothing on SDA and raises neither a read request nor a commit. Its address counter is zero, so a first current-address read returns locations 0, 1, and so on.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start seen at any point, including partway through a byte, abandons the current transfer and begins a new device-address byte.
- R3: The device-address byte carries 1010 in bits 7..4, the three select bits in bits 3..1 (compared against `sel_i[2:0]`), and the direction in bit 0 (1 = read). It is acknowledged in the ninth clock only on a full match. On a mismatch the block stays silent until the next start.
- R4: A write is the device byte, then a high word-address byte, then a low word-address byte, then one data byte, each acknowledged. The block uses only the low `ADDR_W-8` bits of the high byte and ignores the rest. A stop then raises `cm_valid` for exactly one cycle with that address and data.
- R5: A second data byte in the same write is not acknowledged, and the commit still carries the first data byte.
- R6: A stop right after the low address byte loads the counter and commits nothing. A repeated start after the address phase, or after a data byte, also commits nothing.
- R7: From a commit until `BUSY_CYCLES` clocks later, the block acknowledges nothing and never drives SDA. After that it acknowledges its address again.
- R8: A read shifts out 8 bits, most significant first, and then releases SDA for the ninth clock. A master acknowledge starts the next byte. A master non-acknowledge ends the transmission, and SDA stays released until the next start.
- R9: Each byte read advances the counter by one, wrapping from the last array address to 0. A committed write leaves the counter at the next byte of the same 2^`PAGE_W`-byte page, wrapping within that page.
- R10: A random read (a write header with both address bytes, a repeated start, then a read header) returns the byte at the loaded address.
- R11: The block changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low |
| sel_i | input | 3 | Pin-strapped select bits of the device address |
| mem_addr | output | ADDR_W | Read address to the memory (the address counter) |
| mem_rd_en | output | 1 | Read request; data is expected on the next cycle |
| mem_rdata | input | 8 | Read data from the memory |
| cm_valid | output | 1 | One-cycle write-commit request |
| cm_addr | output | ADDR_W | Address of the committed byte |
| cm_data | output | 8 | Committed byte |

## Verification
The bench builds the block with `ADDR_W = 9`, `PAGE_W = 2` and `BUSY_CYCLES = 1500`. The 512-byte array makes the end-of-array wrap of a sequential read reachable in a few bytes. The 4-byte page puts the page wrap of the counter after a write at address 0x0B. The busy window fits several acknowledge polls and still keeps the run short. With three select pins, the bench sweeps all eight select values in both directions, plus every wrong type code, against a fixed strap.

// File: rtl/twi_mem_pkg.sv
// Shared definitions for the two-wire memory slave.
// Assumes nothing beyond IEEE 1800-2017.
package twi_mem_pkg;

    // Fixed device type code carried in bits 7..4 of the device-address byte
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    // Protocol engine states
    typedef enum logic [2:0] {
        S_IDLE,   // waiting for a start
        S_DEV,    // receiving device-address byte
        S_AHI,    // receiving high word-address byte
        S_ALO,    // receiving low word-address byte
        S_WDAT,   // receiving write data
        S_ACK,    // driving acknowledge in the ninth clock
        S_RD,     // shifting a read byte out
        S_RACK    // sampling the master's acknowledge
    } twi_state_e;

endpackage

// File: rtl/twi_line_sampler.sv
// Brings SCL and SDA into the clk domain through a synchronizer chain and
// derives one-cycle event strobes for SCL edges and start/stop conditions.
// Assumes each SCL phase lasts several clk cycles.
module twi_line_sampler #(
    parameter int SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [SYNC_LEN-1:0] scl_ff, sda_ff;
    logic                scl_q, sda_q;
    logic                scl_s;

    // Synchronizer chains plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_LEN-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_LEN-2:0], sda_i};
            scl_q  <= scl_ff[SYNC_LEN-1];
            sda_q  <= sda_ff[SYNC_LEN-1];
        end
    end

    // Event decode on the synchronized lines
    always_comb begin
        scl_s    = scl_ff[SYNC_LEN-1];
        sda_s    = sda_ff[SYNC_LEN-1];
        scl_rise = scl_s & ~scl_q;
        scl_fall = ~scl_s & scl_q;
        start_p  = scl_s & scl_q & sda_q & ~sda_s;
        stop_p   = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/twi_busy_timer.sv
// Counts out the internal write period after each commit.
// Assumes BUSY_CYCLES >= 1; busy is high for BUSY_CYCLES cycles after kick.
module twi_busy_timer #(
    parameter int BUSY_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);

    logic [CW-1:0] remain;

    // Reload on commit, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)            remain <= '0;
        else if (kick)         remain <= LOAD;
        else if (remain != '0) remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/twi_mem_slave.sv
// Two-wire bus slave in front of a byte memory. Handles device addressing,
// a two-byte word address, single-byte write commits, current, random and
// sequential reads, and a busy window after every commit.
// Assumes mem_rdata is valid the cycle after mem_rd_en and ADDR_W > 8.
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PAGE_W      = 5,
    parameter int BUSY_CYCLES = 1000,
    parameter int SYNC_LEN    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        sel_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [7:0]        mem_rdata,
    output logic              cm_valid,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [7:0]        cm_data
);
    localparam int HI_W = ADDR_W - 8;

    logic              sda_s, scl_rise, scl_fall, start_p, stop_p, busy;
    twi_state_e        st, nxt;
    logic [3:0]        cnt;
    logic [7:0]        sr, tx, wbuf;
    logic [HI_W-1:0]   ahi;
    logic [ADDR_W-1:0] ctr;
    logic              have, ld_pend;

    twi_line_sampler #(.SYNC_LEN(SYNC_LEN)) u_smp (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    twi_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .kick(cm_valid), .busy(busy)
    );

    assign mem_addr = ctr;

    // Protocol engine: bit counting, acknowledge, read shift and commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; nxt <= S_IDLE; cnt <= '0; sr <= '0; tx <= '0;
            wbuf <= '0; ahi <= '0; ctr <= '0; have <= 1'b0; ld_pend <= 1'b0;
            sda_oe <= 1'b0; mem_rd_en <= 1'b0; cm_valid <= 1'b0;
            cm_addr <= '0; cm_data <= '0;
        end else begin
            mem_rd_en <= 1'b0;
            cm_valid  <= 1'b0;
            ld_pend   <= mem_rd_en;
            if (ld_pend) begin
                tx  <= mem_rdata;
                ctr <= ctr + 1'b1;
            end
            if (start_p && !busy) begin
                st <= S_DEV; cnt <= '0; have <= 1'b0; sda_oe <= 1'b0;
            end else if (stop_p) begin
                if (have) begin
                    cm_valid <= 1'b1;
                    cm_addr  <= ctr;
                    cm_data  <= wbuf;
                    ctr      <= {ctr[ADDR_W-1:PAGE_W], ctr[PAGE_W-1:0] + 1'b1};
                end
                st <= S_IDLE; have <= 1'b0; sda_oe <= 1'b0;
            end else begin
                case (st)
                    S_DEV, S_AHI, S_ALO, S_WDAT: begin
                        if (scl_rise && cnt < 4'd8) begin
                            sr  <= {sr[6:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            st  <= S_IDLE;
                            if (st == S_DEV) begin
                                if (sr[7:1] == {DEV_TYPE, sel_i}) begin
                                    sda_oe <= 1'b1; st <= S_ACK;
                                    if (sr[0]) begin
                                        nxt <= S_RD; mem_rd_en <= 1'b1;
                                    end else begin
                                        nxt <= S_AHI;
                                    end
                                end
                            end else if (st == S_AHI) begin
                                ahi <= sr[HI_W-1:0];
                                sda_oe <= 1'b1; st <= S_ACK; nxt <= S_ALO;
                            end else if (st == S_ALO) begin
                                ctr <= {ahi, sr};
                                sda_oe <= 1'b1; st <= S_ACK; nxt <= S_WDAT;
                            end else if (!have) begin
                                wbuf <= sr; have <= 1'b1;
                                sda_oe <= 1'b1; st <= S_ACK; nxt <= S_WDAT;
                            end
                        end
                    end
                    S_ACK: if (scl_fall) begin
                        sda_oe <= (nxt == S_RD) ? ~tx[7] : 1'b0;
                        cnt    <= '0;
                        st     <= nxt;
                    end
                    S_RD: if (scl_fall) begin
                        if (cnt == 4'd7) begin
                            sda_oe <= 1'b0; st <= S_RACK;
                        end else begin
                            tx     <= {tx[6:0], 1'b0};
                            sda_oe <= ~tx[6];
                            cnt    <= cnt + 1'b1;
                        end
                    end
                    S_RACK: begin
                        if (scl_rise) begin
                            if (!sda_s) mem_rd_en <= 1'b1;
                            else        st <= S_IDLE;
                        end else if (scl_fall) begin
                            sda_oe <= ~tx[7]; cnt <= '0; st <= S_RD;
                        end
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/twi_mem_slave_chk.sv
// Temporal checks on the two-wire memory slave, attached by bind.
// Assumes BUSY_CYCLES >= 1.
module twi_mem_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic scl_fall,
    input logic start_p,
    input logic stop_p,
    input logic cm_valid,
    input logic busy,
    input logic mem_rd_en
);
    // R11: the data driver moves only after a clock fall or a bus condition
    a_r11_sda_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_p) || $past(stop_p)));

    // R4: a commit is a response to a stop
    a_r4_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |-> $past(stop_p));

    // R4: a commit lasts one cycle
    a_r4_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |=> !cm_valid);

    // R7: a commit opens the busy window
    a_r7_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |=> busy);

    // R7: nothing is driven or read while busy
    a_r7_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!sda_oe && !mem_rd_en));
endmodule

bind twi_mem_slave twi_mem_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .cm_valid(cm_valid),
    .busy(busy), .mem_rd_en(mem_rd_en)
);

// File: tb/sim_twi_mem_slave.sv
`timescale 1ns/1ps
module sim_twi_mem_slave;
    localparam int AW = 9, PW = 2, BUSY = 1500, DEPTH = 1 << AW;
    localparam logic [2:0] PINS = 3'b101;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
    logic sda_oe, mem_rd_en, cm_valid;
    logic [AW-1:0] mem_addr, cm_addr;
    logic [7:0] mem_rdata = 8'h00, cm_data;
    wire sda_bus = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    twi_mem_slave #(.ADDR_W(AW), .PAGE_W(PW), .BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .sel_i(PINS), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_rdata(mem_rdata), .cm_valid(cm_valid), .cm_addr(cm_addr),
        .cm_data(cm_data)
    );

    logic [7:0] mem [DEPTH];
    logic [7:0] expm [DEPTH];
    int n_commit = 0;
    logic [AW-1:0] last_a = '0;
    logic [7:0] last_d = '0;
    int checks = 0, fails = 0, viol = 0;
    logic prev_oe = 1'b0;
    bit done = 0;

    // Memory model: synchronous read, commit writes
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
        if (cm_valid) begin
            mem[cm_addr] <= cm_data;
            n_commit <= n_commit + 1;
            last_a <= cm_addr;
            last_d <= cm_data;
        end
    end

    // R11 monitor: driver changes seen while SCL is high
    always @(negedge clk) begin
        if (sda_oe !== prev_oe && scl) viol <= viol + 1;
        prev_oe <= sda_oe;
    end

    function automatic logic [7:0] seed_val(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wclk(6); scl = 1'b1; wclk(6); sda_m = 1'b0; wclk(6);
        scl = 1'b0; wclk(6);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wclk(6); scl = 1'b1; wclk(6); sda_m = 1'b1; wclk(12);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wclk(6); scl = 1'b1; wclk(8); scl = 1'b0; wclk(6);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wclk(6); scl = 1'b1; wclk(4); ack = ~sda_bus; wclk(4);
        scl = 1'b0; wclk(6);
    endtask

    task automatic get_byte(input logic ack_m, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wclk(6); scl = 1'b1; wclk(4); b[i] = sda_bus; wclk(4);
            scl = 1'b0; wclk(6);
        end
        sda_m = ~ack_m; wclk(6); scl = 1'b1; wclk(8); scl = 1'b0; wclk(6);
        sda_m = 1'b1;
    endtask

    // Write header with both address bytes; leaves the bus after the last ack
    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, output logic ok);
        logic k1, k2, k3;
        bus_start;
        put_byte({4'hA, PINS, 1'b0}, k1);
        put_byte(hi, k2);
        put_byte(lo, k3);
        ok = k1 & k2 & k3;
    endtask

    // Read n bytes from the current position and compare with the model
    task automatic read_n(input string req, input int a0, input int n);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            get_byte(i != n - 1, b);
            check(req, b, expm[(a0 + i) % DEPTH]);
        end
    endtask

    task automatic read_hdr(input string req);
        logic k;
        bus_start;
        put_byte({4'hA, PINS, 1'b1}, k);
        check(req, k, 1);
    endtask

    task automatic wait_idle(output int polls);
        logic k;
        polls = 0;
        for (int i = 0; i < 40; i++) begin
            bus_start; put_byte({4'hA, PINS, 1'b0}, k); bus_stop;
            polls++;
            if (k) break;
            wclk(40);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual hung expected finished");
            summary;
            $finish;
        end
    end

    initial begin
        logic k, ok;
        logic [7:0] b;
        int polls, nc;
        for (int a = 0; a < DEPTH; a++) begin
            mem[a] = seed_val(a);
            expm[a] = seed_val(a);
        end
        wclk(10);
        check("R1 reset outputs", {sda_oe, cm_valid, mem_rd_en}, 0);
        rst_n = 1'b1;
        wclk(10);

        // R1: counter starts at zero; R8: bytes come out MSB first
        read_hdr("R3 read header");
        read_n("R1 R8 first current read", 0, 2);
        bus_stop;

        // R3: sweep of select values and directions
        for (int s = 0; s < 8; s++) begin
            for (int rw = 0; rw < 2; rw++) begin
                bus_start;
                put_byte({4'hA, 3'(s), 1'(rw)}, k);
                check("R3 select sweep", k, (3'(s) == PINS) ? 1 : 0);
                if (k && rw == 1) get_byte(1'b0, b);
                else if (!k) begin
                    put_byte(8'h00, k);
                    check("R3 silent after mismatch", k, 0);
                end
                bus_stop;
            end
        end
        for (int t = 0; t < 16; t++) begin
            if (t == 10) continue;
            bus_start;
            put_byte({4'(t), PINS, 1'b0}, k);
            check("R3 wrong type code", k, 0);
            bus_stop;
        end

        // R4: byte write and its commit
        nc = n_commit;
        set_addr(8'h00, 8'h0B, ok);
        put_byte(8'h5A, k);
        check("R4 write acks", ok & k, 1);
        bus_stop;
        check("R4 one commit", n_commit - nc, 1);
        check("R4 commit address", last_a, 'h0B);
        check("R4 commit data", last_d, 'h5A);
        expm[11] = 8'h5A;

        // R7: no acknowledge during the busy window, then acknowledge again
        bus_start; put_byte({4'hA, PINS, 1'b0}, k); bus_stop;
        check("R7 nack while busy", k, 0);
        wait_idle(polls);
        check("R7 ack after busy", (polls >= 2 && polls < 40) ? 1 : 0, 1);

        // R9: counter after a write at page end wraps inside the page
        read_hdr("R9 header");
        read_n("R9 page wrap after write", 8, 1);
        bus_stop;

        // R10: random read; R6: its dummy write commits nothing
        nc = n_commit;
        set_addr(8'h00, 8'h0B, ok);
        read_hdr("R10 header");
        read_n("R10 random read", 11, 1);
        bus_stop;
        check("R6 dummy write no commit", n_commit - nc, 0);
        read_hdr("R9 header");
        read_n("R9 read increments", 12, 1);
        bus_stop;

        // R5: second data byte is refused, first byte is committed
        nc = n_commit;
        set_addr(8'h00, 8'h20, ok);
        put_byte(8'h11, k);
        put_byte(8'h22, b[0]);
        check("R5 second byte nack", b[0], 0);
        bus_stop;
        check("R5 commit data", last_d, 'h11);
        check("R5 commit address", last_a, 'h20);
        check("R5 one commit", n_commit - nc, 1);
        expm[32] = 8'h11;
        wait_idle(polls);

        // R6: set current address; R4: upper bits of high byte ignored
        nc = n_commit;
        set_addr(8'hF1, 8'hA5, ok);
        bus_stop;
        check("R6 set address no commit", n_commit - nc, 0);
        read_hdr("R6 header");
        read_n("R4 R6 read at loaded address", 'h1A5, 1);
        bus_stop;

        // R8 R9: sequential read across the end of the array
        set_addr(8'h01, 8'hFC, ok);
        read_hdr("R8 header");
        read_n("R8 R9 sequential wrap", 'h1FC, 8);
        get_byte(1'b0, b);
        check("R8 released after nack", b, 'hFF);
        bus_stop;

        // R2: start in the middle of a byte restarts addressing
        bus_start;
        put_byte({4'hA, PINS, 1'b0}, k);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        set_addr(8'h00, 8'h0B, ok);
        check("R2 restart after abort", ok, 1);
        read_hdr("R2 header");
        read_n("R2 read after abort", 11, 1);
        bus_stop;

        // R6: repeated start after a data byte commits nothing
        nc = n_commit;
        set_addr(8'h00, 8'h40, ok);
        put_byte(8'h77, k);
        read_hdr("R6 header");
        read_n("R6 data untouched after restart", 'h40, 1);
        bus_stop;
        wclk(20);
        check("R6 restart no commit", n_commit - nc, 0);

        check("R11 sda moves only with SCL low", viol, 0);

        done = 1;
        summary;
        $finish;
    end
endmodule